// File: doc/BRIEF.md
# Periodic Interrupt Generator

This block turns a 32768 Hz tick-enable into a programmable stream of periodic interrupt events. A 4-bit rate code and an enable bit, both held in control registers elsewhere, pick a period between 4 and 16384 ticks. Each event is a single system-clock pulse, together with a byte-wide set mask that the interrupt status register ORs in to raise its summary flag (bit 7) and its periodic flag (bit 6).

Events are not timed from the moment software writes the rate. A free-running 15-bit tick counter runs from reset, and an event fires whenever that counter reaches a multiple of the selected period. A change of rate or enable therefore takes effect at the next aligned boundary of the new period and never produces a shortened first period. Rate codes 1 and 2 select the same periods as codes 8 and 9.

Top module: `periodic_irq_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `evt_o` is 0 and `stat_set_o` is 0; the tick count restarts from zero, so with code 3 enabled the first event follows the 4th tick after reset.
- R2: A rate code of 0 produces no events, whatever the enable bit.
- R3: With `pie_en` at 0, no events are produced for any rate code.
- R4: For codes 3 to 15 with `pie_en` at 1, the period is 2^(code-1) ticks.
- R5: Code 1 gives the same period as code 8 (128 ticks) and code 2 the same as code 9 (256 ticks).
- R6: An event fires on the tick that brings the tick count since reset to a multiple of the period in force during that tick; changes of code or enable take effect at once, with no partial-period event.
- R7: `evt_o` is high for exactly one system-clock cycle, the cycle after the clock edge that sampled the causing tick, and never in two consecutive cycles.
- R8: `stat_set_o` is 8'hC0 (bits 7 and 6 set) in the cycle `evt_o` is high and 8'h00 otherwise.
- R9: The tick count wraps modulo 32768 and alignment continues across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_en | input | 1 | One-cycle enable at 32768 Hz |
| rate_sel | input | 4 | Rate code; 0 disables |
| pie_en | input | 1 | Periodic interrupt enable |
| evt_o | output | 1 | One-cycle periodic event pulse |
| stat_set_o | output | 8 | Set mask for the interrupt status register |

## Verification
On every cycle the assertions check that an event is a lone pulse, that it follows a sampled tick with a non-zero code and the enable set, and that the tick counter's low bits sit on a boundary of the period that was selected when it fired. Whether the period length is right for each code, the aliasing of codes 1 and 2, the restart of alignment after reset, and the continuation across the counter wrap are shown only by the bench, which runs every code with the enable both on and off, a long run past the wrap, and rate switches in mid-period against a tick model of its own.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int unsigned PIT_RATE_W = 4;
  localparam int unsigned PIT_CNT_W  = 15;
  localparam int unsigned PIT_STAT_W = 8;
  localparam int unsigned PIT_IRQF_BIT = 7;
  localparam int unsigned PIT_PF_BIT   = 6;

  // Low codes alias onto slower rates before the period is derived.
  function automatic logic [PIT_RATE_W-1:0] pit_eff_code(input logic [PIT_RATE_W-1:0] code);
    logic [PIT_RATE_W-1:0] eff;
    case (code)
      4'd1:    eff = 4'd8;
      4'd2:    eff = 4'd9;
      default: eff = code;
    endcase
    return eff;
  endfunction

endpackage

// File: rtl/pit_tick_counter.sv
module pit_tick_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_nxt = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    cnt_d   = cnt_q;
    if (tick_en) begin
      cnt_d = cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pit_rate_decode.sv
module pit_rate_decode
  import pit_pkg::*;
#(
  parameter int unsigned RATE_W = PIT_RATE_W,
  parameter int unsigned CNT_W  = PIT_CNT_W
) (
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              pie_en,
  output logic              active_o,
  output logic [CNT_W-1:0]  mask_o
);

  logic [RATE_W-1:0] eff_code;
  logic [RATE_W:0]   shift_amt;

  always_comb begin
    eff_code  = pit_eff_code(rate_sel);
    shift_amt = {1'b0, eff_code} - {{RATE_W{1'b0}}, 1'b1};
    active_o  = pie_en && (rate_sel != '0);
  end

  // Bit i of the mask belongs to the period when i < code-1.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (eff_code != '0) && (shift_amt > (RATE_W+1)'(i));
  end

endmodule

// File: rtl/pit_boundary_detect.sv
module pit_boundary_detect #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             active,
  input  logic [CNT_W-1:0] mask,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             fire_o
);

  logic fire_d;

  always_comb begin
    fire_d = tick_en && active && ((cnt_nxt & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_o <= 1'b0;
    end else begin
      fire_o <= fire_d;
    end
  end

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pit_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic [PIT_RATE_W-1:0] rate_sel,
  input  logic                  pie_en,
  output logic                  evt_o,
  output logic [PIT_STAT_W-1:0] stat_set_o
);

  logic [PIT_CNT_W-1:0] cnt_q;
  logic [PIT_CNT_W-1:0] cnt_nxt;
  logic [PIT_CNT_W-1:0] period_mask;
  logic                 gen_active;
  logic                 fire;

  pit_tick_counter #(.CNT_W(PIT_CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  pit_rate_decode #(.RATE_W(PIT_RATE_W), .CNT_W(PIT_CNT_W)) u_dec (
    .rate_sel (rate_sel),
    .pie_en   (pie_en),
    .active_o (gen_active),
    .mask_o   (period_mask)
  );

  pit_boundary_detect #(.CNT_W(PIT_CNT_W)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .active  (gen_active),
    .mask    (period_mask),
    .cnt_nxt (cnt_nxt),
    .fire_o  (fire)
  );

  always_comb begin
    evt_o                    = fire;
    stat_set_o               = '0;
    stat_set_o[PIT_IRQF_BIT] = fire;
    stat_set_o[PIT_PF_BIT]   = fire;
  end

endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk
  import pit_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_en,
  input logic [PIT_RATE_W-1:0] rate_sel,
  input logic                  pie_en,
  input logic                  evt_o,
  input logic [PIT_CNT_W-1:0]  cnt_q
);

  logic [PIT_RATE_W-1:0] rate_prev;
  logic [PIT_CNT_W-1:0]  prev_mask;
  int unsigned           prev_eff;

  always_ff @(posedge clk) begin
    rate_prev <= rate_sel;
  end

  always_comb begin
    prev_eff  = (rate_prev == 4'd1) ? 8 : (rate_prev == 4'd2) ? 9 : int'(rate_prev);
    prev_mask = (prev_eff == 0) ? '0 : PIT_CNT_W'((32'd1 << (prev_eff - 1)) - 32'd1);
  end

  // R7
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

  // R7
  evt_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(tick_en));

  // R3
  evt_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(pie_en));

  // R2
  evt_needs_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> ($past(rate_sel) != '0));

  // R6
  evt_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> ((cnt_q & prev_mask) == '0));

endmodule

bind periodic_irq_gen periodic_irq_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .rate_sel (rate_sel),
  .pie_en   (pie_en),
  .evt_o    (evt_o),
  .cnt_q    (cnt_q)
);

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic [3:0] rate_sel;
  logic       pie_en;
  logic       evt_o;
  logic [7:0] stat_set_o;

  int checks;
  int fails;
  int model_cnt;
  string tag;

  periodic_irq_gen u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .rate_sel   (rate_sel),
    .pie_en     (pie_en),
    .evt_o      (evt_o),
    .stat_set_o (stat_set_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int period_of(input int code);
    int eff;
    eff = (code == 1) ? 8 : (code == 2) ? 9 : code;
    return 1 << (eff - 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle at a negedge, then check at the following negedge.
  task automatic step(input bit tk);
    bit exp;
    tick_en = tk;
    exp = 1'b0;
    if (tk) begin
      model_cnt = (model_cnt + 1) % 32768;
      if (pie_en && rate_sel != 0)
        exp = ((model_cnt % period_of(int'(rate_sel))) == 0);
    end
    @(negedge clk);
    check(tk ? tag : "R7", int'(evt_o), int'(exp));
    check("R8", int'(stat_set_o), exp ? 8'hC0 : 8'h00);
  endtask

  task automatic do_reset();
    tick_en = 1'b0;
    rst_n   = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(evt_o), 0);
    check("R1", int'(stat_set_o), 0);
    rst_n = 1'b1;
    model_cnt = 0;
    @(negedge clk);
    check("R1", int'(evt_o), 0);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    checks = 0;
    fails = 0;
    model_cnt = 0;
    rate_sel = 4'd3;
    pie_en = 1'b1;
    tick_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1: first event on the 4th tick after reset with code 3
    tag = "R1";
    for (int i = 0; i < 4; i++) step(1'b1);

    // Sweep every code, enable on and off, with idle gaps between ticks
    for (int code = 0; code < 16; code++) begin
      for (int en = 0; en < 2; en++) begin
        rate_sel = code[3:0];
        pie_en = en[0];
        if (en == 0) tag = "R3";
        else if (code == 0) tag = "R2";
        else if (code == 1 || code == 2) tag = "R5";
        else tag = "R4";
        for (int i = 0; i < 300; i++) begin
          step(1'b1);
          step(1'b0);
        end
      end
    end

    // R5: codes 1 and 2 over several full periods
    tag = "R5";
    rate_sel = 4'd1; pie_en = 1'b1;
    for (int i = 0; i < 600; i++) step(1'b1);
    rate_sel = 4'd2;
    for (int i = 0; i < 800; i++) step(1'b1);

    // R6: switch rates and enable in mid-period
    tag = "R6";
    rate_sel = 4'd6;
    for (int i = 0; i < 13; i++) step(1'b1);
    rate_sel = 4'd4;
    for (int i = 0; i < 21; i++) step(1'b1);
    pie_en = 1'b0;
    for (int i = 0; i < 5; i++) step(1'b1);
    pie_en = 1'b1;
    rate_sel = 4'd5;
    for (int i = 0; i < 70; i++) step(1'b1);

    // R9: slowest rate across the counter wrap
    tag = "R9";
    rate_sel = 4'd15;
    for (int i = 0; i < 33000; i++) step(1'b1);
    rate_sel = 4'd3;
    for (int i = 0; i < 40; i++) step(1'b1);

    // R1: reset mid-run restarts alignment
    do_reset();
    tag = "R1";
    rate_sel = 4'd3;
    for (int i = 0; i < 12; i++) step(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule